// File: doc/BRIEF.md
# Power Mode Sequencer

This block is the finite-state controller that decides which power mode a low-energy radio chip is in and drives one enable line per power or clock domain. It has six modes: RESET, STANDBY, SLEEP, ACTIVE, RX (receive) and TX (transmit). Software and the host link request mode changes. The block turns on the domains of the target mode at once and holds `ready` low until a programmable wake or settle delay has run out. That delay is counted in ticks of a reference strobe, and its length depends on the source and destination modes, the chosen low-speed clock source and whether the radio changes channel.

The named transitions are:
- **boot**: RESET to ACTIVE, on release of `rst_n`.
- **doze**: ACTIVE to SLEEP.
- **park**: ACTIVE to STANDBY.
- **tick-wake**: SLEEP to ACTIVE, on the wake timer.
- **host-wake**: SLEEP or STANDBY to ACTIVE.
- **listen**: ACTIVE to RX.
- **send**: ACTIVE to TX.
- **turnaround**: RX to TX, or TX to RX.
- **idle**: RX or TX to ACTIVE.
- **abort**: any mode to RESET, on assertion of `rst_n`.

Requests that arrive while a delay is counting are held and taken up once the target mode is reached. The mode, the enable vector, the RAM2 retention line and `ready` are all registered.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, asynchronously and regardless of other inputs, `mode_o` is 0 (RESET) and all eight domain enables, `ram2_on` and `ready` are 0. Mode codes: RESET=0, STANDBY=1, SLEEP=2, ACTIVE=3, RX=4, TX=5.
- R2: On the first clock edge after `rst_n` rises, the mode becomes ACTIVE and `ready` stays low until the boot delay has counted out. The boot delay depends on `lsclk_sel`: 0 = no low-speed clock, 1 = ring oscillator, 2 or 3 = crystal. A delay of D ticks ends on the edge that samples the D-th `tick` after the loading edge, and `ready` rises on that edge.
- R3: Enable vector {dig,spi,lso,hso,core,synth,rxc,txc}, registered and following the current or target mode:
  - RESET: 00000000
  - STANDBY: 11000000
  - SLEEP: 11100000
  - ACTIVE: 1,1,L,1,1,0,0,0
  - RX: 1,1,L,1,1,1,1,0
  - TX: 1,1,L,1,1,1,0,1
  
  L is 1 when `lsclk_sel` is non-zero.
- R4: In ACTIVE with no delay running, the priority is `req_rx` > `req_tx` > `req_sleep` > `req_standby`. SLEEP and STANDBY are entered on a single edge. `ready` is 1 only in ACTIVE, RX or TX once their delay has expired.
- R5: SLEEP leaves to ACTIVE on `timer_wake` or `host_wake`, using the sleep-exit delay. STANDBY leaves only on `host_wake`, using a delay that depends on `lsclk_sel`. `timer_wake` has no effect in STANDBY.
- R6: ACTIVE to RX or TX uses a longer delay when `chan_change` is 1 than when it is 0. RX to TX and TX to RX use the turnaround delay. In RX, `req_tx` has priority over `req_idle`; in TX, `req_rx` has priority over `req_idle`. `req_idle` returns to ACTIVE on one edge with `ready` staying 1.
- R7: A mode request (`req_rx`, `req_tx`, `req_sleep`, `req_standby`, `req_idle`) seen while `ready` is low because a delay is counting is latched. It is acted on in the first cycle after the delay ends, and dropped if it does not apply to the mode then reached.
- R8: `ram2_on` is 1 in ACTIVE, RX and TX. On entry to SLEEP or STANDBY it takes the value of `ram2_keep` and holds that value until the mode is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| tick | input | 1 | Reference strobe that the delay counters count |
| host_wake | input | 1 | Wake request from the serial host link |
| timer_wake | input | 1 | Wake-timer expiry |
| req_sleep | input | 1 | Software request for SLEEP |
| req_standby | input | 1 | Software request for STANDBY |
| req_rx | input | 1 | Software request for receive |
| req_tx | input | 1 | Software request for transmit |
| req_idle | input | 1 | Software request to leave the radio for ACTIVE |
| chan_change | input | 1 | Radio entry includes a channel change |
| lsclk_sel | input | 2 | Low-speed clock source: 0 none, 1 ring, 2/3 crystal |
| ram2_keep | input | 1 | Keep RAM2 powered in SLEEP or STANDBY |
| en_dig | output | 1 | Digital regulator enable |
| en_spi | output | 1 | Serial interface enable |
| en_lso | output | 1 | Low-speed oscillator enable |
| en_hso | output | 1 | High-speed oscillator enable |
| en_core | output | 1 | CPU core enable |
| en_synth | output | 1 | Frequency synthesizer enable |
| en_rxc | output | 1 | Receive chain enable |
| en_txc | output | 1 | Transmit chain enable |
| ram2_on | output | 1 | RAM2 retention enable |
| ready | output | 1 | Mode reached and delay expired |
| mode_o | output | 3 | Current mode code |

## Verification
The assertions check on every cycle that:
- receive has priority from a settled ACTIVE;
- STANDBY holds without a host wake;
- a lone idle request in a settled RX returns at once to a ready ACTIVE;
- RAM2 retention stays stable during SLEEP;
- the delay counter holds between ticks.

The exact length of each delay, the latching and dropping of requests made during a delay, the dependence on the clock source and a reset in the middle of a delay can only be shown by the bench's scenarios. The bench compares its behavioural model with every output on every cycle.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;

    typedef enum logic [2:0] {
        M_RESET   = 3'd0,
        M_STANDBY = 3'd1,
        M_SLEEP   = 3'd2,
        M_ACTIVE  = 3'd3,
        M_RX      = 3'd4,
        M_TX      = 3'd5
    } pm_mode_e;

    typedef struct packed {
        logic rx;
        logic tx;
        logic sleep;
        logic stby;
        logic idle;
    } pm_req_t;

    typedef struct packed {
        logic dig;
        logic spi;
        logic lso;
        logic hso;
        logic core;
        logic synth;
        logic rxc;
        logic txc;
    } pm_dom_t;

    localparam logic [1:0] LS_NONE = 2'd0;
    localparam logic [1:0] LS_RING = 2'd1;

    function automatic pm_dom_t dom_table(pm_mode_e m, logic ls_present);
        pm_dom_t d;
        d = '0;
        case (m)
            M_STANDBY: begin
                d.dig = 1'b1;
                d.spi = 1'b1;
            end
            M_SLEEP: begin
                d.dig = 1'b1;
                d.spi = 1'b1;
                d.lso = 1'b1;
            end
            M_ACTIVE, M_RX, M_TX: begin
                d.dig   = 1'b1;
                d.spi   = 1'b1;
                d.lso   = ls_present;
                d.hso   = 1'b1;
                d.core  = 1'b1;
                d.synth = (m != M_ACTIVE);
                d.rxc   = (m == M_RX);
                d.txc   = (m == M_TX);
            end
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic logic is_awake(pm_mode_e m);
        return (m == M_ACTIVE) || (m == M_RX) || (m == M_TX);
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pm_req_latch.sv
module pm_req_latch
    import pm_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold,
    input  pm_req_t live,
    output pm_req_t eff
);

    pm_req_t pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (hold) begin
            pend_q <= pend_q | live;
        end else begin
            pend_q <= '0;
        end
    end

    assign eff = live | pend_q;

endmodule

// File: rtl/pm_dly_sel.sv
module pm_dly_sel
    import pm_seq_pkg::*;
#(
    parameter int unsigned T_RST_NONE = 1500,
    parameter int unsigned T_RST_RING = 7000,
    parameter int unsigned T_RST_XTAL = 94000,
    parameter int unsigned T_SBY_NONE = 420,
    parameter int unsigned T_SBY_RING = 6200,
    parameter int unsigned T_SBY_XTAL = 93000,
    parameter int unsigned T_SLP      = 420,
    parameter int unsigned T_RX_CHG   = 125,
    parameter int unsigned T_RX_SAME  = 61,
    parameter int unsigned T_TX_CHG   = 131,
    parameter int unsigned T_TX_SAME  = 67,
    parameter int unsigned T_TURN     = 150,
    parameter int unsigned CW         = 17
) (
    input  pm_mode_e        from_m,
    input  pm_mode_e        to_m,
    input  logic [1:0]      ls_sel,
    input  logic            chan_chg,
    output logic [CW-1:0]   dly
);

    always_comb begin
        dly = '0;
        if (to_m == M_ACTIVE) begin
            if (from_m == M_RESET) begin
                if (ls_sel == LS_NONE)      dly = CW'(T_RST_NONE);
                else if (ls_sel == LS_RING) dly = CW'(T_RST_RING);
                else                        dly = CW'(T_RST_XTAL);
            end else if (from_m == M_STANDBY) begin
                if (ls_sel == LS_NONE)      dly = CW'(T_SBY_NONE);
                else if (ls_sel == LS_RING) dly = CW'(T_SBY_RING);
                else                        dly = CW'(T_SBY_XTAL);
            end else if (from_m == M_SLEEP) begin
                dly = CW'(T_SLP);
            end
        end else if (to_m == M_RX) begin
            if (from_m == M_ACTIVE) dly = chan_chg ? CW'(T_RX_CHG) : CW'(T_RX_SAME);
            else if (from_m == M_TX) dly = CW'(T_TURN);
        end else if (to_m == M_TX) begin
            if (from_m == M_ACTIVE) dly = chan_chg ? CW'(T_TX_CHG) : CW'(T_TX_SAME);
            else if (from_m == M_RX) dly = CW'(T_TURN);
        end
    end

endmodule

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
    parameter int unsigned CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic          tick,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expire = run && tick && (cnt_q <= CW'(1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pm_seq_pkg::*;
#(
    parameter int unsigned T_RST_NONE = 1500,
    parameter int unsigned T_RST_RING = 7000,
    parameter int unsigned T_RST_XTAL = 94000,
    parameter int unsigned T_SBY_NONE = 420,
    parameter int unsigned T_SBY_RING = 6200,
    parameter int unsigned T_SBY_XTAL = 93000,
    parameter int unsigned T_SLP      = 420,
    parameter int unsigned T_RX_CHG   = 125,
    parameter int unsigned T_RX_SAME  = 61,
    parameter int unsigned T_TX_CHG   = 131,
    parameter int unsigned T_TX_SAME  = 67,
    parameter int unsigned T_TURN     = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       host_wake,
    input  logic       timer_wake,
    input  logic       req_sleep,
    input  logic       req_standby,
    input  logic       req_rx,
    input  logic       req_tx,
    input  logic       req_idle,
    input  logic       chan_change,
    input  logic [1:0] lsclk_sel,
    input  logic       ram2_keep,
    output logic       en_dig,
    output logic       en_spi,
    output logic       en_lso,
    output logic       en_hso,
    output logic       en_core,
    output logic       en_synth,
    output logic       en_rxc,
    output logic       en_txc,
    output logic       ram2_on,
    output logic       ready,
    output logic [2:0] mode_o
);

    localparam int unsigned MAX_A = umax(umax(T_RST_NONE, T_RST_RING), umax(T_RST_XTAL, T_SBY_NONE));
    localparam int unsigned MAX_B = umax(umax(T_SBY_RING, T_SBY_XTAL), umax(T_SLP, T_TURN));
    localparam int unsigned MAX_C = umax(umax(T_RX_CHG, T_RX_SAME), umax(T_TX_CHG, T_TX_SAME));
    localparam int unsigned MAXD  = umax(umax(MAX_A, MAX_B), MAX_C);
    localparam int unsigned CW    = $clog2(MAXD + 1);

    pm_mode_e      mode_q, mode_n;
    logic          busy_q, busy_n;
    logic          ram2_q, ram2_n;
    logic          load;
    logic          expire;
    logic [CW-1:0] dly;
    pm_req_t       live_req, eff_req;
    pm_dom_t       dom_q;
    logic          ready_q;

    assign live_req = '{rx: req_rx, tx: req_tx, sleep: req_sleep,
                        stby: req_standby, idle: req_idle};

    pm_req_latch u_req_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (busy_q),
        .live  (live_req),
        .eff   (eff_req)
    );

    pm_dly_sel #(
        .T_RST_NONE (T_RST_NONE), .T_RST_RING (T_RST_RING), .T_RST_XTAL (T_RST_XTAL),
        .T_SBY_NONE (T_SBY_NONE), .T_SBY_RING (T_SBY_RING), .T_SBY_XTAL (T_SBY_XTAL),
        .T_SLP      (T_SLP),
        .T_RX_CHG   (T_RX_CHG),   .T_RX_SAME  (T_RX_SAME),
        .T_TX_CHG   (T_TX_CHG),   .T_TX_SAME  (T_TX_SAME),
        .T_TURN     (T_TURN),
        .CW         (CW)
    ) u_dly_sel (
        .from_m   (mode_q),
        .to_m     (mode_n),
        .ls_sel   (lsclk_sel),
        .chan_chg (chan_change),
        .dly      (dly)
    );

    pm_tick_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (dly),
        .run      (busy_q),
        .tick     (tick),
        .expire   (expire)
    );

    // next-state decision
    always_comb begin
        mode_n = mode_q;
        busy_n = busy_q;
        ram2_n = ram2_q;
        load   = 1'b0;
        if (busy_q) begin
            if (expire) busy_n = 1'b0;
        end else begin
            unique case (mode_q)
                M_RESET:   mode_n = M_ACTIVE;
                M_ACTIVE: begin
                    if (eff_req.rx)         mode_n = M_RX;
                    else if (eff_req.tx)    mode_n = M_TX;
                    else if (eff_req.sleep) mode_n = M_SLEEP;
                    else if (eff_req.stby)  mode_n = M_STANDBY;
                end
                M_SLEEP:   if (host_wake || timer_wake) mode_n = M_ACTIVE;
                M_STANDBY: if (host_wake) mode_n = M_ACTIVE;
                M_RX: begin
                    if (eff_req.tx)        mode_n = M_TX;
                    else if (eff_req.idle) mode_n = M_ACTIVE;
                end
                M_TX: begin
                    if (eff_req.rx)        mode_n = M_RX;
                    else if (eff_req.idle) mode_n = M_ACTIVE;
                end
                default: mode_n = M_RESET;
            endcase
            if (mode_n != mode_q) begin
                load   = (dly != '0);
                busy_n = (dly != '0);
                if ((mode_n == M_SLEEP) || (mode_n == M_STANDBY)) ram2_n = ram2_keep;
                else                                              ram2_n = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= M_RESET;
            busy_q <= 1'b0;
            ram2_q <= 1'b0;
        end else begin
            mode_q <= mode_n;
            busy_q <= busy_n;
            ram2_q <= ram2_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            dom_q   <= dom_table(mode_n, lsclk_sel != LS_NONE);
            ready_q <= !busy_n && is_awake(mode_n);
        end
    end

    assign en_dig   = dom_q.dig;
    assign en_spi   = dom_q.spi;
    assign en_lso   = dom_q.lso;
    assign en_hso   = dom_q.hso;
    assign en_core  = dom_q.core;
    assign en_synth = dom_q.synth;
    assign en_rxc   = dom_q.rxc;
    assign en_txc   = dom_q.txc;
    assign ram2_on  = ram2_q;
    assign ready    = ready_q;
    assign mode_o   = mode_q;

    // R4
    rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && mode_o == M_ACTIVE && req_rx) |=> (mode_o == M_RX && !ready));

    // R5
    stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_STANDBY && !host_wake) |=> (mode_o == M_STANDBY));

    // R6
    idle_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && mode_o == M_RX && req_idle && !req_tx)
            |=> (mode_o == M_ACTIVE && ready));

    // R8
    ram2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SLEEP && $past(mode_o) == M_SLEEP) |-> $stable(ram2_on));

endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic host_wake = 0, timer_wake = 0, req_sleep = 0, req_standby = 0;
    logic req_rx = 0, req_tx = 0, req_idle = 0, chan_change = 0, ram2_keep = 0;
    logic [1:0] lsclk_sel = 2'd0;
    logic en_dig, en_spi, en_lso, en_hso, en_core, en_synth, en_rxc, en_txc;
    logic ram2_on, ready;
    logic [2:0] mode_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwr_mode_seq #(
        .T_RST_NONE(5), .T_RST_RING(9), .T_RST_XTAL(14),
        .T_SBY_NONE(3), .T_SBY_RING(7), .T_SBY_XTAL(12),
        .T_SLP(4), .T_RX_CHG(6), .T_RX_SAME(2),
        .T_TX_CHG(7), .T_TX_SAME(3), .T_TURN(5)
    ) i_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .host_wake(host_wake),
        .timer_wake(timer_wake), .req_sleep(req_sleep), .req_standby(req_standby),
        .req_rx(req_rx), .req_tx(req_tx), .req_idle(req_idle),
        .chan_change(chan_change), .lsclk_sel(lsclk_sel), .ram2_keep(ram2_keep),
        .en_dig(en_dig), .en_spi(en_spi), .en_lso(en_lso), .en_hso(en_hso),
        .en_core(en_core), .en_synth(en_synth), .en_rxc(en_rxc), .en_txc(en_txc),
        .ram2_on(ram2_on), .ready(ready), .mode_o(mode_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // tick strobe: one pulse every third cycle
    always @(negedge clk) begin
        cyc++;
        tick = (cyc % 3 == 0);
    end

    // ---------------- behavioural reference model ----------------
    int  m_mode, m_cnt, nx, d;
    bit  m_busy, m_ram2, m_ls;
    bit  p_rx, p_tx, p_sl, p_sb, p_id;
    bit  e_rx, e_tx, e_sl, e_sb, e_id;

    function automatic int exp_delay(int f, int t, int ls, bit ch);
        if (f == 0 && t == 3) return (ls == 0) ? 5 : (ls == 1) ? 9 : 14;
        if (f == 1 && t == 3) return (ls == 0) ? 3 : (ls == 1) ? 7 : 12;
        if (f == 2 && t == 3) return 4;
        if (f == 3 && t == 4) return ch ? 6 : 2;
        if (f == 3 && t == 5) return ch ? 7 : 3;
        if ((f == 4 && t == 5) || (f == 5 && t == 4)) return 5;
        return 0;
    endfunction

    function automatic int exp_dom(int m, bit ls);
        case (m)
            1: return 8'b1100_0000;
            2: return 8'b1110_0000;
            3: return {5'b11_0_11, 3'b000} | (ls ? 8'b0010_0000 : 8'b0);
            4: return {5'b11_0_11, 3'b110} | (ls ? 8'b0010_0000 : 8'b0);
            5: return {5'b11_0_11, 3'b101} | (ls ? 8'b0010_0000 : 8'b0);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_busy = 0; m_cnt = 0; m_ram2 = 0; m_ls = 0;
            p_rx = 0; p_tx = 0; p_sl = 0; p_sb = 0; p_id = 0;
        end else begin
            e_rx = req_rx | p_rx; e_tx = req_tx | p_tx; e_sl = req_sleep | p_sl;
            e_sb = req_standby | p_sb; e_id = req_idle | p_id;
            if (m_busy) begin
                p_rx |= req_rx; p_tx |= req_tx; p_sl |= req_sleep;
                p_sb |= req_standby; p_id |= req_idle;
                if (tick) begin
                    if (m_cnt <= 1) m_busy = 0;
                    else m_cnt--;
                end
            end else begin
                p_rx = 0; p_tx = 0; p_sl = 0; p_sb = 0; p_id = 0;
                nx = m_mode;
                case (m_mode)
                    0: nx = 3;
                    3: nx = e_rx ? 4 : e_tx ? 5 : e_sl ? 2 : e_sb ? 1 : 3;
                    2: nx = (host_wake || timer_wake) ? 3 : 2;
                    1: nx = host_wake ? 3 : 1;
                    4: nx = e_tx ? 5 : e_id ? 3 : 4;
                    5: nx = e_rx ? 4 : e_id ? 3 : 5;
                    default: nx = m_mode;
                endcase
                if (nx != m_mode) begin
                    d = exp_delay(m_mode, nx, int'(lsclk_sel), chan_change);
                    m_busy = (d > 0);
                    m_cnt = d;
                    m_ram2 = (nx == 1 || nx == 2) ? ram2_keep : 1'b1;
                    m_mode = nx;
                end
            end
            m_ls = (lsclk_sel != 2'd0);
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            check(m_mode == 0 ? "R1" : (m_mode == 1 || m_mode == 2) ? "R5" :
                  (m_mode == 3) ? "R4" : "R6", int'(mode_o), m_mode);
            check("R3", int'({en_dig, en_spi, en_lso, en_hso, en_core, en_synth, en_rxc, en_txc}),
                  exp_dom(m_mode, m_ls));
            check(m_mode >= 4 ? "R6" : "R2", int'(ready),
                  int'(!m_busy && m_mode >= 3));
            check("R8", int'(ram2_on), int'(m_ram2));
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse(int which);
        @(negedge clk);
        case (which)
            0: req_rx = 1; 1: req_tx = 1; 2: req_sleep = 1;
            3: req_standby = 1; 4: req_idle = 1; 5: host_wake = 1;
            default: timer_wake = 1;
        endcase
        @(negedge clk);
        req_rx = 0; req_tx = 0; req_sleep = 0; req_standby = 0;
        req_idle = 0; host_wake = 0; timer_wake = 0;
    endtask

    task automatic wait_ready(string req);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (ready) break;
        end
        check(req, int'(ready), 1);
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle_cycles(4);
        // R1: reset state
        check("R1", int'(mode_o), 0);
        check("R1", int'({en_dig, en_spi, en_lso, en_hso, en_core, en_synth, en_rxc, en_txc}), 0);
        check("R1", int'(ready), 0);
        check("R1", int'(ram2_on), 0);
        rst_n = 1;
        @(negedge clk);
        check("R2", int'(mode_o), 3);
        check("R2", int'(ready), 0);
        wait_ready("R2");

        // R6: receive with channel change, turnaround, idle
        chan_change = 1;
        pulse(0);
        check("R6", int'(mode_o), 4);
        wait_ready("R6");
        pulse(1);
        check("R6", int'(mode_o), 5);
        wait_ready("R6");
        pulse(4);
        check("R6", int'(mode_o), 3);
        check("R6", int'(ready), 1);

        // R4: receive beats sleep
        chan_change = 0;
        @(negedge clk);
        req_rx = 1; req_sleep = 1;
        @(negedge clk);
        req_rx = 0; req_sleep = 0;
        check("R4", int'(mode_o), 4);
        wait_ready("R4");
        pulse(4);

        // R7: idle latched during a receive delay
        chan_change = 1;
        pulse(0);
        pulse(4);
        wait_ready("R7");
        idle_cycles(3);
        check("R7", int'(mode_o), 3);

        // R7: sleep request during a transmit delay is dropped
        pulse(1);
        pulse(2);
        wait_ready("R7");
        idle_cycles(4);
        check("R7", int'(mode_o), 5);
        pulse(4);

        // R8 / R5: sleep without RAM2, timer wake
        ram2_keep = 0;
        pulse(2);
        check("R4", int'(mode_o), 2);
        check("R4", int'(ready), 0);
        check("R8", int'(ram2_on), 0);
        ram2_keep = 1;
        idle_cycles(5);
        check("R8", int'(ram2_on), 0);
        pulse(6);
        check("R5", int'(mode_o), 3);
        wait_ready("R5");

        // R5: standby ignores timer, wakes on host (ring source)
        lsclk_sel = 2'd1;
        pulse(3);
        check("R8", int'(ram2_on), 1);
        timer_wake = 1;
        idle_cycles(20);
        timer_wake = 0;
        check("R5", int'(mode_o), 1);
        pulse(5);
        wait_ready("R5");
        check("R5", int'(mode_o), 3);

        // sleep woken by host, crystal source
        lsclk_sel = 2'd2;
        pulse(2);
        pulse(5);
        wait_ready("R5");

        // R1: reset in the middle of a standby exit
        pulse(3);
        pulse(5);
        idle_cycles(4);
        rst_n = 0;
        @(negedge clk);
        check("R1", int'(mode_o), 0);
        check("R1", int'(ready), 0);
        check("R1", int'(en_dig), 0);
        idle_cycles(3);
        lsclk_sel = 2'd1;
        rst_n = 1;
        wait_ready("R2");
        lsclk_sel = 2'd3;
        rst_n = 0;
        idle_cycles(2);
        rst_n = 1;
        wait_ready("R2");
        idle_cycles(5);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule